// File: doc/BRIEF.md
# Post-Increment Address Generation Unit

This unit sits between an instruction decoder and the load/store port of a 32-bit core. It handles loads and stores that use post-increment addressing. The access goes to the base register's current value, with no displacement added. The base register then moves by a signed step taken from the instruction. The step arrives as separate instruction bytes, and a format code says whether the step is 8, 24 or 32 bits wide. The unit assembles the step from those bytes and extends it to 32 bits.

An operation is offered for one cycle on `op_valid`.

- **Cycle after issue:** the unit raises a memory request. The request carries the unmodified base as its address, plus byte enables and lane-steered store data.
- **Cycle after the request:** the memory returns read data on `mem_rdata`. In that same cycle the unit presents two write-backs, each on its own port with its own strobe:
  - the advanced base value;
  - for loads only, the loaded data, routed to the destination register.

The register file, the memory and instruction fetch are all outside the unit.

Top module: `agu_postinc`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `mem_req`, `base_we` and `ld_we` are all low.
- R2: One cycle after `op_valid` is high, `mem_req` is high and `mem_addr` equals the `base_val` that was presented with the operation, with nothing added to it.
- R3: With `imm_fmt` = 2'b00, the step is `imm_b0` sign-extended from bit 7 to 32 bits.
- R4: With `imm_fmt` = 2'b01, the step is formed little-endian from `imm_b0` (least significant), `imm_b1` and `imm_b2`, then sign-extended from bit 23 to 32 bits. `imm_b3` has no effect.
- R5: With `imm_fmt` = 2'b10 or 2'b11, the step is {`imm_b3`,`imm_b2`,`imm_b1`,`imm_b0`} used as is.
- R6: Two cycles after `op_valid`, `base_we` is high, `base_wr_idx` equals the operation's `base_idx`, and `base_wr_data` equals `base_val` + step modulo 2^32. This holds for loads and stores of both sizes, whatever the access size.
- R7: `mem_be` is 4'b1111 for a word access (`op_half` = 0). For a halfword access it is 4'b0011 when address bit 1 is 0 and 4'b1100 when bit 1 is 1. For a halfword store, `mem_wdata` carries the low 16 bits of `st_data` in both halves; for a word store it carries `st_data`.
- R8: A store (`op_store` = 1) drives `mem_we` high with its request and never raises `ld_we`.
- R9: A load (`op_store` = 0) drives `mem_we` low. In the same cycle as `base_we`, it raises `ld_we` with `ld_wr_idx` equal to `dst_idx`. `ld_wr_data` is then either the whole `mem_rdata` word (word load) or the half selected by address bit 1, zero-extended (halfword load).
- R10: A cycle without `op_valid` produces no `mem_req` in the next cycle and no write-back strobe two cycles later.
- R11: With `imm_fmt` = 2'b00, bytes `imm_b1`..`imm_b3` have no effect on the base write-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered this cycle |
| op_store | input | 1 | 1 = store, 0 = load |
| op_half | input | 1 | 1 = halfword access, 0 = word access |
| imm_fmt | input | 2 | Step format: 00 8-bit signed, 01 24-bit signed, 10/11 32-bit |
| imm_b0 | input | 8 | Step byte, least significant |
| imm_b1 | input | 8 | Step byte 1 |
| imm_b2 | input | 8 | Step byte 2 |
| imm_b3 | input | 8 | Step byte, most significant |
| base_idx | input | IDX_W | Base register number |
| base_val | input | ADDR_W | Current base register value |
| dst_idx | input | IDX_W | Load destination register number |
| st_data | input | DATA_W | Store source data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Access address (unmodified base) |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a request |
| base_we | output | 1 | Base write-back strobe |
| base_wr_idx | output | IDX_W | Base write-back register number |
| base_wr_data | output | ADDR_W | Advanced base value |
| ld_we | output | 1 | Load data write-back strobe |
| ld_wr_idx | output | IDX_W | Load destination register number |
| ld_wr_data | output | DATA_W | Formatted load data |

## Verification
The assertions assume that an offered base is naturally aligned: bit 0 is always clear, and bit 1 is clear as well for word accesses. They also assume the memory returns read data exactly one cycle after a request. The stimulus masks word bases down to a multiple of four and picks halfword bases with both values of bit 1. The bench memory model answers every request on the following edge with a value computed from the request address. Every combination of direction, size and step format is crossed with step byte patterns that set and clear each sign bit and fill the unused bytes with junk, and with bases that wrap past the top of the address space.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      STEP_S8    = 2'b00,
      STEP_S24   = 2'b01,
      STEP_W32   = 2'b10,
      STEP_W32_B = 2'b11
   } step_fmt_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/agu_step_build.sv
module agu_step_build
   import agu_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned NBYTES = 4
) (
   input  logic [NBYTES*BYTE_W-1:0] bytes_flat,
   input  logic [1:0]               fmt,
   output logic [W-1:0]             step
);
   localparam int unsigned FLAT_W = NBYTES * BYTE_W;

   generate
      if (FLAT_W != W) begin : g_bad_width
         $error("agu_step_build: byte count must cover the word");
      end
   endgenerate

   logic [W-1:0] s8_ext;
   logic [W-1:0] s24_ext;
   logic [W-1:0] w_full;

   assign s8_ext  = {{(W-8){bytes_flat[7]}},   bytes_flat[7:0]};
   assign s24_ext = {{(W-24){bytes_flat[23]}}, bytes_flat[23:0]};
   assign w_full  = bytes_flat[W-1:0];

   always_comb begin
      unique case (step_fmt_e'(fmt))
         STEP_S8:  step = s8_ext;
         STEP_S24: step = s24_ext;
         default:  step = w_full;
      endcase
   end
endmodule

// File: rtl/agu_lane_steer.sv
module agu_lane_steer #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                half,
   input  logic                hi_half,
   input  logic [DATA_W-1:0]   st_data,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   wdata
);
   localparam int unsigned NLANE = DATA_W / 8;
   localparam int unsigned HALF  = DATA_W / 2;

   genvar li;
   generate
      for (li = 0; li < NLANE; li++) begin : g_lane
         localparam bit UPPER = (li >= NLANE / 2);
         assign be[li] = !half || (UPPER == hi_half);
      end
   endgenerate

   assign wdata = half ? {2{st_data[HALF-1:0]}} : st_data;
endmodule

// File: rtl/agu_load_fmt.sv
module agu_load_fmt #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              half,
   input  logic              hi_half,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);
   localparam int unsigned HALF = DATA_W / 2;

   logic [HALF-1:0] picked;

   assign picked = hi_half ? rdata[DATA_W-1:HALF] : rdata[HALF-1:0];
   assign data   = half ? {{HALF{1'b0}}, picked} : rdata;
endmodule

// File: rtl/agu_postinc.sv
module agu_postinc
   import agu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic                op_store,
   input  logic                op_half,
   input  logic [1:0]          imm_fmt,
   input  logic [7:0]          imm_b0,
   input  logic [7:0]          imm_b1,
   input  logic [7:0]          imm_b2,
   input  logic [7:0]          imm_b3,
   input  logic [IDX_W-1:0]    base_idx,
   input  logic [ADDR_W-1:0]   base_val,
   input  logic [IDX_W-1:0]    dst_idx,
   input  logic [DATA_W-1:0]   st_data,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                base_we,
   output logic [IDX_W-1:0]    base_wr_idx,
   output logic [ADDR_W-1:0]   base_wr_data,
   output logic                ld_we,
   output logic [IDX_W-1:0]    ld_wr_idx,
   output logic [DATA_W-1:0]   ld_wr_data
);
   localparam int unsigned NSTEP_BYTES = ADDR_W / BYTE_W;
   localparam int unsigned NLANE       = DATA_W / 8;

   generate
      if (ADDR_W != 32 || DATA_W != 32) begin : g_bad_cfg
         $error("agu_postinc: address and data must both be 32 bits");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("agu_postinc: register index needs at least one bit");
      end
   endgenerate

   // ---------------- step assembly ----------------
   logic [7:0]                    step_byte [NSTEP_BYTES];
   logic [NSTEP_BYTES*BYTE_W-1:0] step_flat;
   logic [ADDR_W-1:0]             step_val;

   assign step_byte[0] = imm_b0;
   assign step_byte[1] = imm_b1;
   assign step_byte[2] = imm_b2;
   assign step_byte[3] = imm_b3;

   genvar bi;
   generate
      for (bi = 0; bi < NSTEP_BYTES; bi++) begin : g_pack
         assign step_flat[bi*BYTE_W +: BYTE_W] = step_byte[bi];
      end
   endgenerate

   agu_step_build #(.W(ADDR_W), .NBYTES(NSTEP_BYTES)) u_step (
      .bytes_flat (step_flat),
      .fmt        (imm_fmt),
      .step       (step_val)
   );

   // ---------------- lane steering ----------------
   logic [NLANE-1:0]  be_nxt;
   logic [DATA_W-1:0] wdata_nxt;

   agu_lane_steer #(.DATA_W(DATA_W)) u_lane (
      .half    (op_half),
      .hi_half (base_val[1]),
      .st_data (st_data),
      .be      (be_nxt),
      .wdata   (wdata_nxt)
   );

   // ---------------- stage 1: request ----------------
   logic              s1_valid;
   logic              s1_store;
   logic              s1_half;
   logic [ADDR_W-1:0] s1_addr;
   logic [ADDR_W-1:0] s1_next;
   logic [IDX_W-1:0]  s1_bidx;
   logic [IDX_W-1:0]  s1_didx;
   logic [NLANE-1:0]  s1_be;
   logic [DATA_W-1:0] s1_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= op_valid;
   end

   always_ff @(posedge clk) begin
      if (op_valid) begin
         s1_store <= op_store;
         s1_half  <= op_half;
         s1_addr  <= base_val;
         s1_next  <= base_val + step_val;
         s1_bidx  <= base_idx;
         s1_didx  <= dst_idx;
         s1_be    <= be_nxt;
         s1_wdata <= wdata_nxt;
      end
   end

   assign mem_req   = s1_valid;
   assign mem_we    = s1_valid & s1_store;
   assign mem_addr  = s1_addr;
   assign mem_be    = s1_be;
   assign mem_wdata = s1_wdata;

   // ---------------- stage 2: write-back ----------------
   logic              s2_valid;
   logic              s2_load;
   logic              s2_half;
   logic              s2_hi;
   logic [ADDR_W-1:0] s2_next;
   logic [IDX_W-1:0]  s2_bidx;
   logic [IDX_W-1:0]  s2_didx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_valid <= 1'b0;
      else        s2_valid <= s1_valid;
   end

   always_ff @(posedge clk) begin
      if (s1_valid) begin
         s2_load <= !s1_store;
         s2_half <= s1_half;
         s2_hi   <= s1_addr[1];
         s2_next <= s1_next;
         s2_bidx <= s1_bidx;
         s2_didx <= s1_didx;
      end
   end

   agu_load_fmt #(.DATA_W(DATA_W)) u_ldfmt (
      .half    (s2_half),
      .hi_half (s2_hi),
      .rdata   (mem_rdata),
      .data    (ld_wr_data)
   );

   assign base_we      = s2_valid;
   assign base_wr_idx  = s2_bidx;
   assign base_wr_data = s2_next;
   assign ld_we        = s2_valid & s2_load;
   assign ld_wr_idx    = s2_didx;

   // ---------------- assertions ----------------
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (base_val[0] == 1'b0 && (op_half || base_val[1] == 1'b0))); // R7
   AST_REQ_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> mem_req); // R2
   AST_ADDR_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (mem_addr == $past(base_val))); // R2
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !mem_req); // R10
   AST_WB_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> base_we); // R6
   AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |=> !base_we); // R10
   AST_STORE_NO_LD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> !ld_we); // R8
   AST_LOAD_HAS_LD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> ld_we); // R9
   AST_LD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |-> base_we); // R9
   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == NLANE || $countones(mem_be) == NLANE/2)); // R7
endmodule

// File: tb/sim_agu_postinc.sv
module sim_agu_postinc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_store = 1'b0, op_half = 1'b0;
   logic [1:0]  imm_fmt = 2'b00;
   logic [7:0]  imm_b0 = '0, imm_b1 = '0, imm_b2 = '0, imm_b3 = '0;
   logic [3:0]  base_idx = '0, dst_idx = '0;
   logic [31:0] base_val = '0, st_data = '0;
   logic        mem_req, mem_we, base_we, ld_we;
   logic [31:0] mem_addr, mem_wdata, base_wr_data, ld_wr_data;
   logic [3:0]  mem_be, base_wr_idx, ld_wr_idx;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   agu_postinc u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
      .op_half(op_half), .imm_fmt(imm_fmt), .imm_b0(imm_b0), .imm_b1(imm_b1),
      .imm_b2(imm_b2), .imm_b3(imm_b3), .base_idx(base_idx), .base_val(base_val),
      .dst_idx(dst_idx), .st_data(st_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .base_we(base_we), .base_wr_idx(base_wr_idx),
      .base_wr_data(base_wr_data), .ld_we(ld_we), .ld_wr_idx(ld_wr_idx),
      .ld_wr_data(ld_wr_data)
   );

   function automatic logic [31:0] mem_model(input logic [31:0] a);
      return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
   endfunction

   // memory: answers one cycle after each request
   always @(posedge clk) mem_rdata <= mem_req ? mem_model(mem_addr) : 32'h0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_step(input logic [1:0] f, input logic [31:0] bb);
      longint v;
      if (f == 2'b00) begin
         v = longint'(bb[7:0]);
         if (v > 127) v -= 256;
      end else if (f == 2'b01) begin
         v = longint'(bb[7:0]) + longint'(bb[15:8]) * 256 + longint'(bb[23:16]) * 65536;
         if (v >= 64'sd8388608) v -= 64'sd16777216;
      end else begin
         v = longint'(bb);
      end
      return v[31:0];
   endfunction

   task automatic run_vec(input bit st, input bit hf, input logic [1:0] f,
                          input logic [31:0] bb, input logic [31:0] base);
      logic [31:0] step_e, base_e, rd_e, wd_e;
      logic [3:0]  be_e;
      string       sreq;
      step_e = exp_step(f, bb);
      base_e = base + step_e;
      sreq = (f == 2'b00) ? "R3 R11 R6" : (f == 2'b01) ? "R4 R6" : "R5 R6";
      be_e = !hf ? 4'b1111 : (base[1] ? 4'b1100 : 4'b0011);
      wd_e = !hf ? (base ^ 32'h1357_9BDF) : {2{(base[15:0] ^ 16'h9BDF)}};
      rd_e = mem_model(base);
      if (hf) rd_e = base[1] ? {16'h0, rd_e[31:16]} : {16'h0, rd_e[15:0]};

      @(negedge clk);
      op_valid = 1'b1; op_store = st; op_half = hf; imm_fmt = f;
      imm_b0 = bb[7:0]; imm_b1 = bb[15:8]; imm_b2 = bb[23:16]; imm_b3 = bb[31:24];
      base_val = base; st_data = base ^ 32'h1357_9BDF;
      base_idx = base[5:2]; dst_idx = ~base[5:2];
      @(negedge clk);
      op_valid = 1'b0;
      chk(mem_req === 1'b1, "R2", "mem_req", {31'h0, mem_req}, 32'h1);
      chk(mem_addr === base, "R2", "mem_addr", mem_addr, base);
      chk(mem_we === st, st ? "R8" : "R9", "mem_we", {31'h0, mem_we}, {31'h0, st});
      chk(mem_be === be_e, "R7", "mem_be", {28'h0, mem_be}, {28'h0, be_e});
      if (st) chk(mem_wdata === wd_e, "R7", "mem_wdata", mem_wdata, wd_e);
      chk(base_we === 1'b0, "R10", "base_we early", {31'h0, base_we}, 32'h0);
      @(negedge clk);
      chk(mem_req === 1'b0, "R10", "mem_req idle", {31'h0, mem_req}, 32'h0);
      chk(base_we === 1'b1, "R6", "base_we", {31'h0, base_we}, 32'h1);
      chk(base_wr_idx === base[5:2], "R6", "base_wr_idx",
          {28'h0, base_wr_idx}, {28'h0, base[5:2]});
      chk(base_wr_data === base_e, sreq, "base_wr_data", base_wr_data, base_e);
      chk(ld_we === !st, st ? "R8" : "R9", "ld_we", {31'h0, ld_we}, {31'h0, !st});
      if (!st) begin
         chk(ld_wr_idx === ~base[5:2], "R9", "ld_wr_idx",
             {28'h0, ld_wr_idx}, {28'h0, ~base[5:2]});
         chk(ld_wr_data === rd_e, "R9", "ld_wr_data", ld_wr_data, rd_e);
      end
   endtask

   logic [31:0] pats  [6] = '{32'h0000_0004, 32'hFFFF_FFFE, 32'h1280_0080,
                              32'hA57F_FF7F, 32'h0180_0000, 32'h8000_0001};
   logic [31:0] bases [3] = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h7FFF_FFF2};

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_req === 1'b0, "R1", "mem_req in reset", {31'h0, mem_req}, 32'h0);
      chk(base_we === 1'b0, "R1", "base_we in reset", {31'h0, base_we}, 32'h0);
      chk(ld_we === 1'b0, "R1", "ld_we in reset", {31'h0, ld_we}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req === 1'b0, "R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);
      chk(base_we === 1'b0, "R1", "base_we after reset", {31'h0, base_we}, 32'h0);
      chk(ld_we === 1'b0, "R1", "ld_we after reset", {31'h0, ld_we}, 32'h0);
      for (int s = 0; s < 2; s++)
         for (int h = 0; h < 2; h++)
            for (int f = 0; f < 4; f++)
               for (int p = 0; p < 6; p++)
                  for (int b = 0; b < 3; b++)
                     run_vec(s[0], h[0], f[1:0], pats[p],
                             h[0] ? bases[b] : (bases[b] & 32'hFFFF_FFFC));
      @(negedge clk);
      chk(base_we === 1'b0, "R10", "base_we drained", {31'h0, base_we}, 32'h0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule